// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a small set of memory blocks in a directory-based cache coherence scheme shared by `SITES` caching sites. Each block has a directory entry with a protocol state, a site vector (the sharer set in the shared states, a one-hot owner in the owned states), a count of outstanding invalidation acknowledgements, the site being served, and the kind of request being served. The block's data lives in a small internal array. The network is taken to be reliable and to keep order between any one source and destination.

Messages from the caches come in on a single input channel with a valid/ready handshake. They are shared and exclusive requests, and writeback, invalidate and flush responses. Messages to the caches leave on a registered output channel, one per cycle. They are writeback, invalidate and flush requests, and shared and exclusive replies. A request that reaches a block while the block waits on other sites is held in one slot and replayed when the block settles.

The controller has two states. In IDLE it accepts or replays one message per cycle. In INV it sends the invalidations of one exclusive request, one per cycle. The directory states are RD (readable, memory valid), OWN (one site holds a modified copy), RD_WAIT (waiting for invalidation acknowledgements) and OWN_WAIT (waiting for the owner's data). The directory transitions are:
- RD to RD on a shared request.
- RD to OWN on an exclusive request with no other sharer.
- RD to RD_WAIT on an exclusive request with other sharers.
- RD_WAIT to OWN on the last acknowledgement.
- OWN to OWN_WAIT on any request.
- OWN_WAIT to RD on a writeback response.
- OWN_WAIT to OWN on a flush response.

Top module: `dhc_home`

## Requirements
- R1: After reset every block is RD with an empty sharer set, and block b holds the data value (b*17+5) mod 2^DATA_W. `out_valid` is low and `in_ready` is high.
- R2: The input kind codes are 0 shared request, 1 exclusive request, 2 writeback response, 3 invalidate acknowledgement and 4 flush response. The output kind codes are 0 writeback request, 1 invalidate request, 2 flush request, 3 shared reply and 4 exclusive reply. Request messages on the output carry data 0. The output is registered and appears the cycle after the message that causes it is accepted.
- R3: A shared request to an RD block is answered with a shared reply carrying the block's memory data, and the requester joins the sharer set.
- R4: A shared request to an OWN block sends a writeback request to the owner and moves the block to OWN_WAIT. A writeback response from that owner stores its data, moves the block to RD with sharers {owner, requester}, and sends a shared reply carrying that data to the requester.
- R5: An exclusive request to an RD block that has sharers other than the requester sends one invalidate request per cycle to each of those sharers, in ascending site order. The block enters RD_WAIT with a count equal to the number of those sharers. Each acknowledgement from a pending sharer lowers the count. The last acknowledgement sends an exclusive reply with the memory data and makes the requester the owner.
- R6: An exclusive request to an RD block whose sharer set is empty, or holds only the requester, is answered at once with an exclusive reply carrying the memory data, and no invalidate request is sent.
- R7: An exclusive request to an OWN block sends a flush request to the owner and moves the block to OWN_WAIT. A flush response from that owner stores its data, sends an exclusive reply with that data to the requester, and makes the requester the owner.
- R8: In OWN and OWN_WAIT exactly one site is recorded, so the dirty condition equals those two states.
- R9: A request to a block in RD_WAIT or OWN_WAIT produces no output and is held. It is processed as soon as the block returns to RD or OWN, before any further input. While it is held, `in_ready` is low for every request.
- R10: A response that does not match the block's waiting state or its expected sender is ignored: no output, and no change to the directory or the memory.
- R11: Each block's directory entry and data are independent: traffic to one block leaves the others' behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message accepted this cycle when valid |
| in_kind | input | 3 | Incoming message kind (R2 codes) |
| in_site | input | $clog2(SITES) | Sending site |
| in_blk | input | $clog2(BLOCKS) | Block addressed |
| in_data | input | DATA_W | Data carried by writeback and flush responses |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 3 | Outgoing message kind (R2 codes) |
| out_site | output | $clog2(SITES) | Destination site |
| out_blk | output | $clog2(BLOCKS) | Block addressed |
| out_data | output | DATA_W | Data of replies, 0 for requests |

## Verification
The hardest case to reach is the held request. A second request must land on a block that is waiting on acknowledgements. The acknowledgements then complete, and the replay must turn straight into a further wait on the new owner. The stimulus builds two sharers, issues an exclusive request from a third site, and sends a shared request from a fourth site while the invalidations are still owed. It also tries one more request to show that it is refused. It then returns the acknowledgements one by one and answers the writeback that the replay raises. A behavioural model of the directory predicts the ordered stream of outgoing messages, and that stream is compared message by message.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    typedef enum logic [1:0] {
        DS_RD       = 2'd0,
        DS_OWN      = 2'd1,
        DS_RD_WAIT  = 2'd2,
        DS_OWN_WAIT = 2'd3
    } dir_state_e;

    typedef enum logic [2:0] {
        MI_SHREQ    = 3'd0,
        MI_EXREQ    = 3'd1,
        MI_WBRSP    = 3'd2,
        MI_INVACK   = 3'd3,
        MI_FLUSHRSP = 3'd4
    } msg_in_e;

    typedef enum logic [2:0] {
        MO_WBREQ    = 3'd0,
        MO_INVREQ   = 3'd1,
        MO_FLUSHREQ = 3'd2,
        MO_SHRPL    = 3'd3,
        MO_EXRPL    = 3'd4
    } msg_out_e;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_INV  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/dhc_lowbit.sv
module dhc_lowbit #(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // index of the lowest set bit, zero when none is set
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dhc_dir_table.sv
module dhc_dir_table
    import dhc_pkg::*;
#(
    parameter int SITES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 8,
    parameter int SID_W  = 2,
    parameter int BID_W  = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_en,
    input  logic [BID_W-1:0]  w_blk,
    input  dir_state_e        w_state,
    input  logic [SITES-1:0]  w_vec,
    input  logic [CNT_W-1:0]  w_cnt,
    input  logic [SID_W-1:0]  w_req,
    input  logic              w_ex,
    input  logic              m_en,
    input  logic [DATA_W-1:0] m_data,
    output dir_state_e        t_state [BLOCKS],
    output logic [SITES-1:0]  t_vec   [BLOCKS],
    output logic [CNT_W-1:0]  t_cnt   [BLOCKS],
    output logic [SID_W-1:0]  t_req   [BLOCKS],
    output logic              t_ex    [BLOCKS],
    output logic [DATA_W-1:0] t_mem   [BLOCKS]
);
    for (genvar b = 0; b < BLOCKS; b++) begin : g_ent
        logic hit;
        assign hit = (w_blk == BID_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_state[b] <= DS_RD;
                t_vec[b]   <= '0;
                t_cnt[b]   <= '0;
                t_req[b]   <= '0;
                t_ex[b]    <= 1'b0;
            end else if (w_en && hit) begin
                t_state[b] <= w_state;
                t_vec[b]   <= w_vec;
                t_cnt[b]   <= w_cnt;
                t_req[b]   <= w_req;
                t_ex[b]    <= w_ex;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_mem[b] <= DATA_W'(b * 17 + 5);
            end else if (m_en && hit) begin
                t_mem[b] <= m_data;
            end
        end
    end
endmodule

// File: rtl/dhc_home.sv
module dhc_home
    import dhc_pkg::*;
#(
    parameter int SITES  = 4,
    parameter int BLOCKS = 4,
    parameter int DATA_W = 8,
    localparam int SID_W = (SITES  > 1) ? $clog2(SITES)  : 1,
    localparam int BID_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [SID_W-1:0]  in_site,
    input  logic [BID_W-1:0]  in_blk,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [SID_W-1:0]  out_site,
    output logic [BID_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data
);
    localparam int CNT_W = $clog2(SITES + 1);

    // controller and holding state
    ctl_state_e        fsm_q, fsm_d;
    logic              held_v_q, held_v_d;
    logic              held_ex_q, held_ex_d;
    logic [SID_W-1:0]  held_site_q, held_site_d;
    logic [BID_W-1:0]  held_blk_q, held_blk_d;
    logic [SITES-1:0]  inv_mask_q, inv_mask_d;
    logic [BID_W-1:0]  inv_blk_q, inv_blk_d;

    // directory table
    dir_state_e        t_state [BLOCKS];
    logic [SITES-1:0]  t_vec   [BLOCKS];
    logic [CNT_W-1:0]  t_cnt   [BLOCKS];
    logic [SID_W-1:0]  t_req   [BLOCKS];
    logic              t_ex    [BLOCKS];
    logic [DATA_W-1:0] t_mem   [BLOCKS];

    logic              w_en, m_en, w_ex;
    dir_state_e        w_state;
    logic [SITES-1:0]  w_vec;
    logic [CNT_W-1:0]  w_cnt;
    logic [SID_W-1:0]  w_req;
    logic [DATA_W-1:0] m_data;

    // operation under decision
    logic              replay, in_is_req, op_v;
    msg_in_e           op_kind;
    logic [SID_W-1:0]  op_site;
    logic [BID_W-1:0]  op_blk;
    logic [DATA_W-1:0] op_data;
    dir_state_e        held_state;

    dir_state_e        e_state;
    logic [SITES-1:0]  e_vec, req_bit, ereq_bit, others, scan_bit;
    logic [CNT_W-1:0]  e_cnt;
    logic [SID_W-1:0]  e_req, own_idx, scan_idx;
    logic              e_ex;
    logic [DATA_W-1:0] e_mem;

    // outgoing message before its register
    logic              o_v;
    msg_out_e          o_kind;
    logic [SID_W-1:0]  o_site;
    logic [BID_W-1:0]  o_blk;
    logic [DATA_W-1:0] o_data;

    dhc_dir_table #(
        .SITES(SITES), .BLOCKS(BLOCKS), .DATA_W(DATA_W),
        .SID_W(SID_W), .BID_W(BID_W), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .w_en(w_en), .w_blk(op_blk), .w_state(w_state), .w_vec(w_vec),
        .w_cnt(w_cnt), .w_req(w_req), .w_ex(w_ex),
        .m_en(m_en), .m_data(m_data),
        .t_state(t_state), .t_vec(t_vec), .t_cnt(t_cnt),
        .t_req(t_req), .t_ex(t_ex), .t_mem(t_mem)
    );

    dhc_lowbit #(.W(SITES), .IW(SID_W)) u_owner (.vec(e_vec),      .idx(own_idx));
    dhc_lowbit #(.W(SITES), .IW(SID_W)) u_scan  (.vec(inv_mask_q), .idx(scan_idx));

    assign held_state = t_state[held_blk_q];
    assign replay     = (fsm_q == CS_IDLE) && held_v_q &&
                        (held_state == DS_RD || held_state == DS_OWN);
    assign in_is_req  = (in_kind == MI_SHREQ) || (in_kind == MI_EXREQ);
    assign in_ready   = (fsm_q == CS_IDLE) && !replay && !(in_is_req && held_v_q);
    assign op_v       = replay || (in_valid && in_ready);

    always_comb begin
        if (replay) begin
            op_kind = held_ex_q ? MI_EXREQ : MI_SHREQ;
            op_site = held_site_q;
            op_blk  = held_blk_q;
            op_data = '0;
        end else begin
            op_kind = msg_in_e'(in_kind);
            op_site = in_site;
            op_blk  = in_blk;
            op_data = in_data;
        end
    end

    assign e_state  = t_state[op_blk];
    assign e_vec    = t_vec[op_blk];
    assign e_cnt    = t_cnt[op_blk];
    assign e_req    = t_req[op_blk];
    assign e_ex     = t_ex[op_blk];
    assign e_mem    = t_mem[op_blk];
    assign req_bit  = SITES'(1) << op_site;
    assign ereq_bit = SITES'(1) << e_req;
    assign others   = e_vec & ~req_bit;
    assign scan_bit = SITES'(1) << scan_idx;

    // next state, directory update and outgoing message
    always_comb begin
        fsm_d       = fsm_q;
        held_v_d    = held_v_q;
        held_ex_d   = held_ex_q;
        held_site_d = held_site_q;
        held_blk_d  = held_blk_q;
        inv_mask_d  = inv_mask_q;
        inv_blk_d   = inv_blk_q;
        w_en        = 1'b0;
        w_state     = e_state;
        w_vec       = e_vec;
        w_cnt       = e_cnt;
        w_req       = e_req;
        w_ex        = e_ex;
        m_en        = 1'b0;
        m_data      = op_data;
        o_v         = 1'b0;
        o_kind      = MO_WBREQ;
        o_site      = '0;
        o_blk       = op_blk;
        o_data      = '0;

        unique case (fsm_q)
            CS_INV: begin
                o_v        = 1'b1;
                o_kind     = MO_INVREQ;
                o_site     = scan_idx;
                o_blk      = inv_blk_q;
                inv_mask_d = inv_mask_q & ~scan_bit;
                if (inv_mask_d == '0) begin
                    fsm_d = CS_IDLE;
                end
            end
            CS_IDLE: begin
                if (op_v) begin
                    if (replay) begin
                        held_v_d = 1'b0;
                    end
                    case (op_kind)
                        MI_SHREQ, MI_EXREQ: begin
                            unique case (e_state)
                                DS_RD_WAIT, DS_OWN_WAIT: begin
                                    held_v_d    = 1'b1;
                                    held_ex_d   = (op_kind == MI_EXREQ);
                                    held_site_d = op_site;
                                    held_blk_d  = op_blk;
                                end
                                DS_RD: begin
                                    w_en = 1'b1;
                                    o_v  = 1'b1;
                                    if (op_kind == MI_SHREQ) begin
                                        w_vec  = e_vec | req_bit;
                                        o_kind = MO_SHRPL;
                                        o_site = op_site;
                                        o_data = e_mem;
                                    end else if (others == '0) begin
                                        w_state = DS_OWN;
                                        w_vec   = req_bit;
                                        o_kind  = MO_EXRPL;
                                        o_site  = op_site;
                                        o_data  = e_mem;
                                    end else begin
                                        o_v        = 1'b0;
                                        w_state    = DS_RD_WAIT;
                                        w_cnt      = CNT_W'($countones(others));
                                        w_req      = op_site;
                                        w_ex       = 1'b1;
                                        fsm_d      = CS_INV;
                                        inv_mask_d = others;
                                        inv_blk_d  = op_blk;
                                    end
                                end
                                DS_OWN: begin
                                    w_en    = 1'b1;
                                    w_state = DS_OWN_WAIT;
                                    w_req   = op_site;
                                    w_ex    = (op_kind == MI_EXREQ);
                                    o_v     = 1'b1;
                                    o_kind  = (op_kind == MI_EXREQ) ? MO_FLUSHREQ : MO_WBREQ;
                                    o_site  = own_idx;
                                end
                            endcase
                        end
                        MI_WBRSP: begin
                            if (e_state == DS_OWN_WAIT && !e_ex && op_site == own_idx) begin
                                m_en    = 1'b1;
                                w_en    = 1'b1;
                                w_state = DS_RD;
                                w_vec   = e_vec | ereq_bit;
                                o_v     = 1'b1;
                                o_kind  = MO_SHRPL;
                                o_site  = e_req;
                                o_data  = op_data;
                            end
                        end
                        MI_FLUSHRSP: begin
                            if (e_state == DS_OWN_WAIT && e_ex && op_site == own_idx) begin
                                m_en    = 1'b1;
                                w_en    = 1'b1;
                                w_state = DS_OWN;
                                w_vec   = ereq_bit;
                                o_v     = 1'b1;
                                o_kind  = MO_EXRPL;
                                o_site  = e_req;
                                o_data  = op_data;
                            end
                        end
                        MI_INVACK: begin
                            if (e_state == DS_RD_WAIT && e_vec[op_site] && op_site != e_req) begin
                                w_en  = 1'b1;
                                w_vec = e_vec & ~req_bit;
                                w_cnt = e_cnt - CNT_W'(1);
                                if (e_cnt == CNT_W'(1)) begin
                                    w_state = DS_OWN;
                                    w_vec   = ereq_bit;
                                    o_v     = 1'b1;
                                    o_kind  = MO_EXRPL;
                                    o_site  = e_req;
                                    o_data  = e_mem;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    // controller state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= CS_IDLE;
            held_v_q    <= 1'b0;
            held_ex_q   <= 1'b0;
            held_site_q <= '0;
            held_blk_q  <= '0;
            inv_mask_q  <= '0;
            inv_blk_q   <= '0;
        end else begin
            fsm_q       <= fsm_d;
            held_v_q    <= held_v_d;
            held_ex_q   <= held_ex_d;
            held_site_q <= held_site_d;
            held_blk_q  <= held_blk_d;
            inv_mask_q  <= inv_mask_d;
            inv_blk_q   <= inv_blk_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_site  <= '0;
            out_blk   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= o_v;
            out_kind  <= o_kind;
            out_site  <= o_site;
            out_blk   <= o_blk;
            out_data  <= o_data;
        end
    end
endmodule

// File: rtl/dhc_home_chk.sv
module dhc_home_chk
    import dhc_pkg::*;
#(
    parameter int SITES  = 4,
    parameter int BLOCKS = 4,
    parameter int SID_W  = 2,
    parameter int CNT_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_kind,
    input logic             out_valid,
    input logic [2:0]       out_kind,
    input logic             inv_busy,
    input logic             held_v,
    input dir_state_e       st  [BLOCKS],
    input logic [SITES-1:0] vec [BLOCKS],
    input logic [CNT_W-1:0] cnt [BLOCKS],
    input logic [SID_W-1:0] req [BLOCKS]
);
    // R5
    inv_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |=> (out_valid && out_kind == 3'(MO_INVREQ)));

    // R9
    held_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_kind == 3'(MI_SHREQ) || in_kind == 3'(MI_EXREQ)))
        |-> !held_v);

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        // R8
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st[b] == DS_OWN || st[b] == DS_OWN_WAIT) |-> $onehot(vec[b]));

        // R5
        ack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st[b] == DS_RD_WAIT) |->
            (cnt[b] != '0 &&
             32'(cnt[b]) == $countones(vec[b] & ~(SITES'(1) << req[b]))));
    end
endmodule

bind dhc_home dhc_home_chk #(
    .SITES(SITES), .BLOCKS(BLOCKS), .SID_W(SID_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .out_valid(out_valid), .out_kind(out_kind),
    .inv_busy(fsm_q == CS_INV), .held_v(held_v_q),
    .st(t_state), .vec(t_vec), .cnt(t_cnt), .req(t_req)
);

// File: tb/dhc_home_bench.sv
module dhc_home_bench;
    localparam int K  = 4;
    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_kind = '0;
    logic [1:0] in_site = '0;
    logic [1:0] in_blk = '0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [2:0] out_kind;
    logic [1:0] out_site;
    logic [1:0] out_blk;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    dhc_home #(.SITES(K), .BLOCKS(NB), .DATA_W(8)) u_dhc_home (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_site(in_site), .in_blk(in_blk), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_site(out_site),
        .out_blk(out_blk), .out_data(out_data)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] k;
        logic [1:0] s;
        logic [1:0] b;
        logic [7:0] d;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // behavioural directory model: 0 RD, 1 OWN, 2 RD_WAIT, 3 OWN_WAIT
    int         mst [NB];
    logic [3:0] mvec[NB];
    int         mcnt[NB];
    int         mreq[NB];
    bit         mex [NB];
    logic [7:0] mmem[NB];
    bit hv, hex;
    int hs, hb;

    function automatic void push(int k, int s, int b, int d, string tag);
        exp_t e;
        e.k = 3'(k); e.s = 2'(s); e.b = 2'(b); e.d = 8'(d); e.tag = tag;
        exp_q.push_back(e);
    endfunction

    function automatic int owner_of(int b);
        for (int i = K - 1; i >= 0; i--) if (mvec[b][i]) return i;
        return 0;
    endfunction

    function automatic void m_req(bit ex, int s, int b);
        logic [3:0] oth;
        if (mst[b] >= 2) begin
            hv = 1; hex = ex; hs = s; hb = b;   // R9 held
            return;
        end
        if (mst[b] == 1) begin
            push(ex ? 2 : 0, owner_of(b), b, 0, ex ? "R7" : "R4");
            mst[b] = 3; mreq[b] = s; mex[b] = ex;
            return;
        end
        if (!ex) begin
            push(3, s, b, mmem[b], "R3");
            mvec[b][s] = 1'b1;
            return;
        end
        oth = mvec[b] & ~(4'b1 << s);
        if (oth == 0) begin
            push(4, s, b, mmem[b], "R6");
            mst[b] = 1; mvec[b] = 4'b1 << s;
        end else begin
            mcnt[b] = 0;
            for (int i = 0; i < K; i++) if (oth[i]) begin
                push(1, i, b, 0, "R5");
                mcnt[b]++;
            end
            mst[b] = 2; mreq[b] = s; mex[b] = 1;
        end
    endfunction

    function automatic void m_rsp(int k, int s, int b, int d);
        if (k == 2 && mst[b] == 3 && !mex[b] && s == owner_of(b)) begin
            mmem[b] = 8'(d); mst[b] = 0;
            mvec[b] = mvec[b] | (4'b1 << mreq[b]);
            push(3, mreq[b], b, d, "R4");
        end else if (k == 4 && mst[b] == 3 && mex[b] && s == owner_of(b)) begin
            mmem[b] = 8'(d); mst[b] = 1; mvec[b] = 4'b1 << mreq[b];
            push(4, mreq[b], b, d, "R7");
        end else if (k == 3 && mst[b] == 2 && mvec[b][s] && s != mreq[b]) begin
            mvec[b][s] = 1'b0; mcnt[b]--;
            if (mcnt[b] == 0) begin
                mst[b] = 1; mvec[b] = 4'b1 << mreq[b];
                push(4, mreq[b], b, mmem[b], "R5");
            end
        end
        // anything else: R10, no effect
        if (hv && mst[hb] < 2) begin
            hv = 0;
            m_req(hex, hs, hb);  // R9 replay
        end
    endfunction

    task automatic send(int k, int s, int b, int d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 3'(k); in_site = 2'(s); in_blk = 2'(b); in_data = 8'(d);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        if (k < 2) m_req(k == 1, s, b);
        else m_rsp(k, s, b, d);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain(string tag);
        repeat (8) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL %s: %0d expected messages missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    // compare the outgoing stream on every clock
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R2: unexpected message kind=%0d site=%0d blk=%0d data=%h, expected none",
                         out_kind, out_site, out_blk, out_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if ({out_kind, out_site, out_blk, out_data} !== {e.k, e.s, e.b, e.d}) begin
                    miscompares++;
                    $display("FAIL %s: got kind=%0d site=%0d blk=%0d data=%h, expected kind=%0d site=%0d blk=%0d data=%h",
                             e.tag, out_kind, out_site, out_blk, out_data, e.k, e.s, e.b, e.d);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            mst[b] = 0; mvec[b] = '0; mcnt[b] = 0; mreq[b] = 0; mex[b] = 0;
            mmem[b] = 8'(b * 17 + 5);
        end
        hv = 0; hex = 0; hs = 0; hb = 0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        vectors++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            miscompares++;
            $display("FAIL R1: out_valid=%b in_ready=%b, expected 0 and 1", out_valid, in_ready);
        end

        // R3 two readers of block 0
        send(0, 0, 0, 0);
        send(0, 1, 0, 0);
        drain("R3");

        // R5 invalidation fan-out, R9 held shared request from site 3
        send(1, 2, 0, 0);
        send(0, 3, 0, 0);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 3'd0; in_site = 2'd1; in_blk = 2'd1;
        @(negedge clk);
        vectors++;
        if (in_ready !== 1'b0) begin
            miscompares++;
            $display("FAIL R9: in_ready=%b with a request held, expected 0", in_ready);
        end
        in_valid = 1'b0;
        send(3, 0, 0, 0);
        send(3, 0, 0, 0);   // R10 duplicate acknowledgement ignored
        send(3, 1, 0, 0);   // last ack: exclusive reply, then replay raises writeback
        send(2, 2, 0, 8'h5A);
        drain("R9");

        // R5 single invalidation, then R7 flush path
        send(1, 3, 0, 0);
        send(3, 2, 0, 0);
        send(1, 1, 0, 0);
        send(4, 3, 0, 8'h77);
        drain("R7");

        // R6 sole sharer upgrade and empty-set exclusive
        send(0, 2, 1, 0);
        send(1, 2, 1, 0);
        send(1, 0, 2, 0);
        drain("R6");

        // R10 stray responses to an RD block leave it untouched
        send(3, 1, 3, 0);
        send(2, 1, 3, 8'hEE);
        send(4, 1, 3, 8'hEE);
        send(0, 1, 3, 0);
        drain("R10");

        // R11 independent blocks, R10 wrong sender during a flush
        send(1, 0, 1, 0);
        send(0, 3, 3, 0);
        send(4, 3, 1, 8'h11);
        send(2, 2, 1, 8'h22);
        send(4, 2, 1, 8'h99);
        send(1, 0, 3, 0);
        send(3, 1, 3, 0);
        drain("R11");

        // R4 read of an owned block returns the written-back data
        send(0, 1, 2, 0);
        send(2, 0, 2, 8'h3C);
        send(0, 3, 2, 0);
        drain("R4");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule